// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a system clock into the bit timing of a CAN node. A programmable prescaler divides the clock into time quanta. A segment sequencer then steps each bit through three segments: a one-quantum sync segment, a first phase segment, and a second phase segment. At the boundary between the two phase segments it captures the synchronised receive line. At the start of every bit it issues a strobe that the frame logic uses to update the transmit line.

The sequencer follows the bus in two ways. A falling edge on the receive line while the bus is idle restarts the bit. A falling edge during a frame moves the bit boundary. If the edge is seen in the first phase segment, that segment is lengthened. If it is seen in the second phase segment, that segment is shortened. The size of each adjustment is limited by a programmable jump width.

Two byte-wide configuration registers hold the timing. They accept writes only while the standby input is high, so a running bus cannot be disturbed by a stray write.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, the prescaler register reads 00h and the timing register reads 23h. Bit 7 of the timing register always reads 0.
- R2: A write with `cfg_sel_i`=0 loads the prescaler register and a write with `cfg_sel_i`=1 loads the timing register. A write takes effect only when `standby_i` is high in the same clock. At any other time the write leaves both registers unchanged.
- R3: The quantum lasts (P+1) clocks, where P is bits 5:0 of the prescaler register. `tq_tick_o` pulses high for one clock in the last clock of each quantum.
- R4: A bit lasts (S1+S2+3) quanta, where S1 is bits 3:0 and S2 is bits 6:4 of the timing register. `tx_update_o` is a one-clock pulse at the start of each sync segment.
- R5: `sample_strobe_o` is a one-clock pulse that starts (S1+2) quanta after `tx_update_o`. With it, `sample_bit_o` takes the synchronised value of `rx_i`.
- R6: `rx_i` passes through two flops. A falling edge is detected when the synchronised value is 0 at the end of a quantum and was 1 at the end of the previous quantum. If `bus_idle_i` is high when the edge is detected, the detecting quantum becomes the sync segment, so the sample strobe follows S1+1 quanta later. With P=0 this is S1+4 clocks after `rx_i` falls.
- R7: An edge detected in phase segment 1, at zero-based quantum index c, lengthens that segment by min(c+1, J+1) quanta, where J is bits 7:6 of the prescaler register.
- R8: An edge detected in phase segment 2, at index c, has error e = S2+1-c. If e > J+1, the segment is shortened by J+1 quanta. Otherwise the detecting quantum becomes the sync segment of a new bit, and `tx_update_o` pulses at the end of that quantum.
- R9: At most one adjustment is made per bit. Rising edges are never used.
- R10: When `skip_own_i` is high and `tx_i` is dominant (0), a detected edge is ignored.
- R11: `seg_o` reads 0 in the sync segment, 1 in phase segment 1 and 2 in phase segment 2. It changes only at the end of a quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Controller in standby; enables register writes |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 1 | Register select: 0 prescaler, 1 timing |
| cfg_wdata_i | input | 8 | Write data |
| rx_i | input | 1 | Raw receive line (0 = dominant) |
| tx_i | input | 1 | Level currently being transmitted |
| bus_idle_i | input | 1 | Bus idle; edges trigger a hard restart |
| skip_own_i | input | 1 | Ignore edges while transmitting dominant |
| pre_rd_o | output | 8 | Prescaler register value |
| tim_rd_o | output | 8 | Timing register value |
| tq_tick_o | output | 1 | Last clock of each quantum |
| seg_o | output | 2 | Current segment |
| sample_strobe_o | output | 1 | Sample point pulse |
| sample_bit_o | output | 1 | Last sampled bus value |
| tx_update_o | output | 1 | Start-of-bit pulse |

## Verification
A register write shows on the read ports one clock after the write. Every bit-level check is timed from an observed `tx_update_o` pulse. Counting from there with P=0, the strobe is due after S1+2 clocks and the next start of bit after the bit length in quanta. A falling `rx_i` driven k clocks after that pulse is detected in quantum index k+1 of phase segment 1, because the two synchroniser flops and the edge compare each add one clock. The bench derives its expected bit lengths from that index and the R7 and R8 rules. Every output is sampled on the falling clock edge, after all registers have settled.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_BRP_W  = 6;
    localparam int unsigned DEF_SJW_W  = 2;
    localparam int unsigned DEF_TS1_W  = 4;
    localparam int unsigned DEF_TS2_W  = 3;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BRP_W  = 6,
    parameter int unsigned SJW_W  = 2,
    parameter int unsigned TS1_W  = 4,
    parameter int unsigned TS2_W  = 3,
    parameter logic [DATA_W-1:0] PRE_RST = 8'h00,
    parameter logic [DATA_W-1:0] TIM_RST = 8'h23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              standby_i,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [BRP_W-1:0]  brp_o,
    output logic [SJW_W-1:0]  sjw_o,
    output logic [TS1_W-1:0]  ts1_o,
    output logic [TS2_W-1:0]  ts2_o,
    output logic [DATA_W-1:0] pre_rd_o,
    output logic [DATA_W-1:0] tim_rd_o
);

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic [TS1_W-1:0] ts1;
        logic [TS2_W-1:0] ts2;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;

    assign wr_ok = we_i && standby_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok && !sel_i) begin
            cfg_d.brp = wdata_i[BRP_W-1:0];
            cfg_d.sjw = wdata_i[BRP_W +: SJW_W];
        end
        if (wr_ok && sel_i) begin
            cfg_d.ts1 = wdata_i[TS1_W-1:0];
            cfg_d.ts2 = wdata_i[TS1_W +: TS2_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.brp <= PRE_RST[BRP_W-1:0];
            cfg_q.sjw <= PRE_RST[BRP_W +: SJW_W];
            cfg_q.ts1 <= TIM_RST[TS1_W-1:0];
            cfg_q.ts2 <= TIM_RST[TS1_W +: TS2_W];
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign brp_o    = cfg_q.brp;
    assign sjw_o    = cfg_q.sjw;
    assign ts1_o    = cfg_q.ts1;
    assign ts2_o    = cfg_q.ts2;
    assign pre_rd_o = DATA_W'({cfg_q.sjw, cfg_q.brp});
    assign tim_rd_o = DATA_W'({cfg_q.ts2, cfg_q.ts1});

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
    parameter int unsigned BRP_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;

    // >= keeps the divider bounded when the divisor shrinks mid-count
    assign tick_o = (st_q.cnt >= brp_i);

    always_comb begin
        st_d = st_q;
        if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    input  logic tick_i,
    output logic rx_o,
    output logic fall_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } rxs_t;

    rxs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = rx_i;
        st_d.sync = st_q.meta;
        if (tick_i) begin
            st_d.prev = st_q.sync;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_o   = st_q.sync;
    assign fall_o = tick_i && st_q.prev && !st_q.sync;

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int unsigned SJW_W = 2,
    parameter int unsigned TS1_W = 4,
    parameter int unsigned TS2_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             fall_i,
    input  logic             rx_i,
    input  logic             bus_idle_i,
    input  logic             skip_own_i,
    input  logic             tx_i,
    input  logic [SJW_W-1:0] sjw_i,
    input  logic [TS1_W-1:0] ts1_i,
    input  logic [TS2_W-1:0] ts2_i,
    output seg_e             seg_o,
    output logic             strobe_o,
    output logic             sample_o,
    output logic             txu_o
);

    localparam int unsigned MAX_A = (TS1_W > SJW_W) ? TS1_W : SJW_W;
    localparam int unsigned MAX_B = (MAX_A > TS2_W) ? MAX_A : TS2_W;
    localparam int unsigned CNT_W = MAX_B + 2;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t ONE = cnt_t'(1);

    typedef struct packed {
        seg_e seg;
        cnt_t qcnt;
        cnt_t ext;
        cnt_t cut;
        logic done;
        logic strobe;
        logic sample;
        logic txu;
    } seq_t;

    seq_t st_d, st_q;

    cnt_t jw, t1, t2, err, ext_n, cut_n, end1, end2;
    logic edge_ok, full;

    always_comb begin
        jw      = cnt_t'(sjw_i) + ONE;
        t1      = cnt_t'(ts1_i);
        t2      = cnt_t'(ts2_i);
        edge_ok = fall_i && !(skip_own_i && !tx_i);
        err     = '0;
        ext_n   = st_q.ext;
        cut_n   = st_q.cut;
        end1    = '0;
        end2    = '0;
        full    = 1'b0;

        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.txu    = 1'b0;

        if (tick_i) begin
            if (edge_ok && bus_idle_i) begin
                // hard restart: the detecting quantum counts as sync
                st_d.seg  = SEG_PH1;
                st_d.qcnt = '0;
                st_d.ext  = '0;
                st_d.cut  = '0;
                st_d.done = 1'b1;
            end else begin
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg  = SEG_PH1;
                        st_d.qcnt = '0;
                        st_d.ext  = '0;
                        st_d.cut  = '0;
                    end
                    SEG_PH1: begin
                        if (edge_ok && !st_q.done) begin
                            err       = st_q.qcnt + ONE;
                            ext_n     = (err < jw) ? err : jw;
                            st_d.done = 1'b1;
                        end
                        end1     = t1 + ext_n;
                        st_d.ext = ext_n;
                        if (st_q.qcnt >= end1) begin
                            st_d.seg    = SEG_PH2;
                            st_d.qcnt   = '0;
                            st_d.strobe = 1'b1;
                            st_d.sample = rx_i;
                        end else begin
                            st_d.qcnt = st_q.qcnt + ONE;
                        end
                    end
                    SEG_PH2: begin
                        if (edge_ok && !st_q.done) begin
                            err = (st_q.qcnt > t2) ? ONE : (t2 - st_q.qcnt + ONE);
                            if (err <= jw) begin
                                full = 1'b1;
                            end else begin
                                cut_n = jw;
                            end
                            st_d.done = 1'b1;
                        end
                        end2 = (cut_n > t2) ? '0 : (t2 - cut_n);
                        if (full) begin
                            st_d.seg  = SEG_PH1;
                            st_d.qcnt = '0;
                            st_d.ext  = '0;
                            st_d.cut  = '0;
                            st_d.txu  = 1'b1;
                        end else if (st_q.qcnt >= end2) begin
                            st_d.seg  = SEG_SYNC;
                            st_d.qcnt = '0;
                            st_d.ext  = '0;
                            st_d.cut  = '0;
                            st_d.done = 1'b0;
                            st_d.txu  = 1'b1;
                        end else begin
                            st_d.qcnt = st_q.qcnt + ONE;
                            st_d.cut  = cut_n;
                        end
                    end
                    default: begin
                        st_d.seg  = SEG_SYNC;
                        st_d.qcnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.seg    <= SEG_SYNC;
            st_q.qcnt   <= '0;
            st_q.ext    <= '0;
            st_q.cut    <= '0;
            st_q.done   <= 1'b0;
            st_q.strobe <= 1'b0;
            st_q.sample <= 1'b1;
            st_q.txu    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o    = st_q.seg;
    assign strobe_o = st_q.strobe;
    assign sample_o = st_q.sample;
    assign txu_o    = st_q.txu;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned BRP_W  = DEF_BRP_W,
    parameter int unsigned SJW_W  = DEF_SJW_W,
    parameter int unsigned TS1_W  = DEF_TS1_W,
    parameter int unsigned TS2_W  = DEF_TS2_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              standby_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              rx_i,
    input  logic              tx_i,
    input  logic              bus_idle_i,
    input  logic              skip_own_i,
    output logic [DATA_W-1:0] pre_rd_o,
    output logic [DATA_W-1:0] tim_rd_o,
    output logic              tq_tick_o,
    output logic [1:0]        seg_o,
    output logic              sample_strobe_o,
    output logic              sample_bit_o,
    output logic              tx_update_o
);

    logic [BRP_W-1:0] brp_w;
    logic [SJW_W-1:0] sjw_w;
    logic [TS1_W-1:0] ts1_w;
    logic [TS2_W-1:0] ts2_w;
    logic             tick_w, rx_w, fall_w;
    seg_e             seg_w;

    can_bt_cfg #(
        .DATA_W(DATA_W), .BRP_W(BRP_W), .SJW_W(SJW_W),
        .TS1_W(TS1_W), .TS2_W(TS2_W)
    ) i_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .standby_i(standby_i),
        .we_i     (cfg_we_i),
        .sel_i    (cfg_sel_i),
        .wdata_i  (cfg_wdata_i),
        .brp_o    (brp_w),
        .sjw_o    (sjw_w),
        .ts1_o    (ts1_w),
        .ts2_o    (ts2_w),
        .pre_rd_o (pre_rd_o),
        .tim_rd_o (tim_rd_o)
    );

    can_bt_presc #(.BRP_W(BRP_W)) i_presc (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .brp_i (brp_w),
        .tick_o(tick_w)
    );

    can_bt_rxsync i_rxsync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .rx_i  (rx_i),
        .tick_i(tick_w),
        .rx_o  (rx_w),
        .fall_o(fall_w)
    );

    can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_w),
        .fall_i    (fall_w),
        .rx_i      (rx_w),
        .bus_idle_i(bus_idle_i),
        .skip_own_i(skip_own_i),
        .tx_i      (tx_i),
        .sjw_i     (sjw_w),
        .ts1_i     (ts1_w),
        .ts2_i     (ts2_w),
        .seg_o     (seg_w),
        .strobe_o  (sample_strobe_o),
        .sample_o  (sample_bit_o),
        .txu_o     (tx_update_o)
    );

    assign tq_tick_o = tick_w;
    assign seg_o     = seg_w;

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              standby_i,
    input logic [DATA_W-1:0] pre_rd_o,
    input logic [DATA_W-1:0] tim_rd_o,
    input logic              tq_tick_o,
    input logic [1:0]        seg_o,
    input logic              sample_strobe_o,
    input logic              tx_update_o
);

    assert_locked_regs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !standby_i |=> ($stable(pre_rd_o) && $stable(tim_rd_o)));

    assert_tim_msb_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tim_rd_o[DATA_W-1] == 1'b0);

    assert_txu_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_update_o |=> !tx_update_o);

    assert_strobe_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_strobe_o |=> !sample_strobe_o);

    assert_strobe_in_ph2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_strobe_o |-> (seg_o == 2'd2));

    assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_strobe_o && tx_update_o));

    assert_seg_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_o != 2'd3);

    assert_seg_on_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(seg_o) |-> $past(tq_tick_o));

endmodule

bind can_bit_timer can_bit_timer_chk #(.DATA_W(DATA_W)) i_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .standby_i      (standby_i),
    .pre_rd_o       (pre_rd_o),
    .tim_rd_o       (tim_rd_o),
    .tq_tick_o      (tq_tick_o),
    .seg_o          (seg_o),
    .sample_strobe_o(sample_strobe_o),
    .tx_update_o    (tx_update_o)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       standby_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic       rx_i = 1'b1;
    logic       tx_i = 1'b1;
    logic       bus_idle_i = 1'b0;
    logic       skip_own_i = 1'b0;
    logic [7:0] pre_rd_o, tim_rd_o;
    logic       tq_tick_o, sample_strobe_o, sample_bit_o, tx_update_o;
    logic [1:0] seg_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk_i = ~clk_i;

    can_bit_timer i_can_bit_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .rx_i(rx_i), .tx_i(tx_i), .bus_idle_i(bus_idle_i), .skip_own_i(skip_own_i),
        .pre_rd_o(pre_rd_o), .tim_rd_o(tim_rd_o), .tq_tick_o(tq_tick_o),
        .seg_o(seg_o), .sample_strobe_o(sample_strobe_o),
        .sample_bit_o(sample_bit_o), .tx_update_o(tx_update_o)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] data, input logic stby);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data; standby_i = stby;
        @(negedge clk_i);
        cfg_we_i = 1'b0; standby_i = 1'b0;
    endtask

    task automatic wait_txu();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk_i);
            if (tx_update_o) return;
        end
    endtask

    // Drives rx relative to a start-of-bit pulse; f1/r1/f2 < 0 means unused.
    task automatic run_bit(input int f1, input int r1, input int f2,
                           input logic txv, input logic skipv,
                           output int period, output int soff,
                           output int sbit, output int seg_s, output int seg_e);
        wait_txu();
        tx_i = txv; skip_own_i = skipv;
        if (f1 == 0) rx_i = 1'b0;
        period = 0; soff = -1; sbit = -1; seg_s = -1; seg_e = -1;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk_i); @(negedge clk_i);
            period++;
            if (period == f1) rx_i = 1'b0;
            if (period == r1) rx_i = 1'b1;
            if (period == f2) rx_i = 1'b0;
            if (sample_strobe_o && soff < 0) begin
                soff = period; sbit = int'(sample_bit_o); seg_s = int'(seg_o);
            end
            if (tx_update_o) begin
                seg_e = int'(seg_o);
                break;
            end
        end
        rx_i = 1'b1; tx_i = 1'b1; skip_own_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk_i);
        chk("R1 prescaler reset", int'(pre_rd_o), 'h00);
        chk("R1 timing reset", int'(tim_rd_o), 'h23);
        chk("R11 seg at reset", int'(seg_o), 0);
        chk("R5 strobe low in reset", int'(sample_strobe_o), 0);
        chk("R4 txu low in reset", int'(tx_update_o), 0);
        @(negedge clk_i); rst_ni = 1'b1;
    endtask

    task automatic t_default_bit();
        int p, so, sb, ss, se;
        run_bit(-1, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R4 reset bit length 3+2+3", p, 8);
        chk("R5 reset strobe offset", so, 5);
        chk("R5 sampled recessive", sb, 1);
    endtask

    task automatic t_cfg();
        cfg_write(1'b0, 8'h40, 1'b1);
        @(negedge clk_i);
        chk("R2 prescaler write in standby", int'(pre_rd_o), 'h40);
        cfg_write(1'b1, 8'hB7, 1'b1);
        @(negedge clk_i);
        chk("R1 R2 timing write, bit7 reads 0", int'(tim_rd_o), 'h37);
        cfg_write(1'b0, 8'hFF, 1'b0);
        @(negedge clk_i);
        chk("R2 prescaler write outside standby ignored", int'(pre_rd_o), 'h40);
        cfg_write(1'b1, 8'h11, 1'b0);
        @(negedge clk_i);
        chk("R2 timing write outside standby ignored", int'(tim_rd_o), 'h37);
    endtask

    task automatic t_nominal();
        int p, so, sb, ss, se, gap;
        run_bit(-1, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R4 nominal bit 7+3+3", p, 13);
        chk("R5 strobe offset S1+2", so, 9);
        chk("R11 seg at strobe", ss, 2);
        chk("R11 seg at bit start", se, 0);
        cfg_write(1'b0, 8'h42, 1'b1);
        run_bit(-1, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        run_bit(-1, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R3 bit of 13 quanta at 3 clocks", p, 39);
        chk("R3 R5 strobe offset scaled", so, 27);
        @(negedge clk_i);
        while (!tq_tick_o) @(negedge clk_i);
        gap = 0;
        do begin @(negedge clk_i); gap++; end while (!tq_tick_o && gap < 100);
        chk("R3 tick spacing", gap, 3);
        cfg_write(1'b0, 8'h40, 1'b1);
        run_bit(-1, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
    endtask

    task automatic t_hard();
        int cnt, sb;
        wait_txu();
        bus_idle_i = 1'b1; rx_i = 1'b0;
        cnt = 0; sb = -1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk_i); @(negedge clk_i);
            cnt++;
            if (sample_strobe_o) begin sb = int'(sample_bit_o); break; end
        end
        bus_idle_i = 1'b0;
        chk("R6 hard sync strobe delay S1+4", cnt, 11);
        chk("R6 sampled dominant", sb, 0);
    endtask

    task automatic t_rising();
        int p, so, sb, ss, se;
        // rx still low from the previous task; only a rise occurs in this bit
        run_bit(-1, 2, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R9 rising edge not used", p, 13);
        chk("R5 sampled after rise", sb, 1);
    endtask

    task automatic t_lengthen();
        int p, so, sb, ss, se;
        run_bit(0, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R7 lengthen by 2", p, 15);
        chk("R5 sampled dominant", sb, 0);
        cfg_write(1'b0, 8'hC0, 1'b1);
        run_bit(0, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R7 lengthen by phase error under limit", p, 15);
        run_bit(4, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R7 lengthen limited to J+1", p, 17);
        chk("R7 strobe moves with extension", so, 13);
    endtask

    task automatic t_shorten();
        int p, so, sb, ss, se;
        cfg_write(1'b0, 8'h40, 1'b1);
        run_bit(7, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R8 shorten by 2", p, 11);
        cfg_write(1'b0, 8'h00, 1'b1);
        run_bit(7, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R8 shorten limited to 1", p, 12);
        cfg_write(1'b0, 8'hC0, 1'b1);
        run_bit(7, -1, -1, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R8 edge quantum becomes sync", p, 10);
        chk("R8 new bit already in segment 1", se, 1);
    endtask

    task automatic t_once_and_own();
        int p, so, sb, ss, se;
        cfg_write(1'b0, 8'h40, 1'b1);
        run_bit(0, 4, 5, 1'b1, 1'b0, p, so, sb, ss, se);
        chk("R9 second edge in bit ignored", p, 15);
        run_bit(0, -1, -1, 1'b0, 1'b1, p, so, sb, ss, se);
        chk("R10 own dominant edge ignored", p, 13);
        run_bit(0, -1, -1, 1'b0, 1'b0, p, so, sb, ss, se);
        chk("R10 edge used when not skipping", p, 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_default_bit();
        t_cfg();
        t_nominal();
        t_hard();
        t_rising();
        t_lengthen();
        t_shorten();
        t_once_and_own();
        repeat (4) @(negedge clk_i);
        finish_run();
    end

endmodule